// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is the slave side of an I2C-style two-wire bus in front of a byte-wide register store. It oversamples the clock and data lines with the system clock, spots START and STOP conditions, and compares a 7-bit device identity. After an acknowledged write header it takes a two-byte memory pointer (upper byte first) and then any number of data bytes. After an acknowledged read header it streams bytes from the pointer for as long as the master acknowledges them.

One pointer register serves writes, current-pointer reads and selective reads. Every byte that crosses the bus moves the pointer forward by one. The pointer is 13 bits wide and rolls over from 1FFFh to 0000h. A selective read is an address-only write followed by a repeated START with the read bit set. The data line is open-drain: `sda_oe` high pulls the wire low. The block has no streaming data interface at its edge, so no valid/ready rules apply. Every pin is a plain level.

Top module: `i2c_mem_slave`

## Requirements
- R1: While reset is held and right after it is released, `sda_oe` is 0, the pointer is 0000h and every stored byte reads back as 00h.
- R2: The slave acknowledges (drives the 9th bit low) a header byte whose bits [7:1] equal `DEV_ID`. On any other identity it leaves `sda_oe` at 0 through that byte and every later byte until the next START.
- R3: A write header (bit 0 = 0) is followed by the pointer's upper bits (low 5 bits of the byte), then its lower 8 bits, then data bytes. Each of these bytes is acknowledged, and each data byte is stored at the pointer.
- R4: The pointer increases by exactly one for each data byte written or each byte loaded for transmission. It changes otherwise only when the lower pointer byte is loaded.
- R5: A read header (bit 0 = 1) without a preceding pointer load returns data starting at the byte just after the last one accessed.
- R6: An address-only write followed by a repeated START and a read header returns data from the loaded pointer.
- R7: Advancing the pointer from 1FFFh gives 0000h, for both writes and reads.
- R8: A read may end with NACK then STOP, NACK then START, STOP in the 9th clock, or START in the 9th clock. In every case `sda_oe` is 0 afterwards, and the pointer sits just after the last byte sent.
- R9: When the master acknowledges in the 9th clock of a read byte, the next sequential byte is sent MSB first, starting at the falling SCL edge that ends the acknowledge.
- R10: `sda_oe` changes only while the synchronised SCL is low.
- R11: The store holds 2^`STORE_AW` bytes (512 by default). Pointer value p addresses byte p mod 2^`STORE_AW`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (ACK or a 0 data bit) |

## Verification
The assertions check on every cycle that the data-line enable never moves while SCL is high and stays off after a rejected identity. They also check that it is off right after any START or STOP, and that the pointer only ever steps by one or takes a freshly loaded value. The pointer behaviour itself is shown only by the bench's scenarios: rollover at 1FFFh, aliasing into the smaller store, pointer continuity across separate transactions, and the four read endings. These need whole byte sequences compared against a reference memory.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK,
    ST_IGNORE
  } slv_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_AHI,
    K_ALO,
    K_WDAT
  } byte_kind_e;

  function automatic byte_kind_e next_kind(input byte_kind_e k);
    case (k)
      K_DEV:   return K_AHI;
      K_AHI:   return K_ALO;
      default: return K_WDAT;
    endcase
  endfunction
endpackage

// File: rtl/i2c_mem_sync.sv
module i2c_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_p,
  output logic stop_p
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  // data edges while the clock line is held high
  assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_mem_store.sv
module i2c_mem_store #(
  parameter int DW = 8,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2c_mem_pkg::*;
#(
  parameter logic [6:0] DEV_ID   = 7'h50,
  parameter int         ADDR_W   = 13,
  parameter int         STORE_AW = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  localparam int HI_BITS = ADDR_W - 8;
  localparam int CNT_W   = 4;
  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(8);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(7);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

  i2c_mem_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_p(start_p), .stop_p(stop_p)
  );

  slv_state_e         state_q;
  byte_kind_e         kind_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [7:0]         shreg_q;
  logic [7:0]         txbuf_q;
  logic [HI_BITS-1:0] hi_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               rw_q;
  logic               mack_q;
  logic               oe_q;

  logic               wr_en;
  logic [7:0]         rd_data;

  assign wr_en = (state_q == ST_RX) && (kind_q == K_WDAT) && scl_fall &&
                 (cnt_q == FULL_BYTE) && !start_p && !stop_p;

  i2c_mem_store #(.DW(8), .AW(STORE_AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_en),
    .waddr(addr_q[STORE_AW-1:0]), .wdata(shreg_q),
    .raddr(addr_q[STORE_AW-1:0]), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      shreg_q <= '0;
      txbuf_q <= '0;
      hi_q    <= '0;
      addr_q  <= '0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else if (start_p) begin
      state_q <= ST_RX;
      kind_q  <= K_DEV;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else if (stop_p) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && cnt_q != FULL_BYTE) begin
            shreg_q <= {shreg_q[6:0], sda_s};
            cnt_q   <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL_BYTE) begin
            state_q <= ST_ACK;
            oe_q    <= 1'b1;
            case (kind_q)
              K_DEV: begin
                if (shreg_q[7:1] == DEV_ID) begin
                  rw_q <= shreg_q[0];
                end else begin
                  state_q <= ST_IGNORE;
                  oe_q    <= 1'b0;
                end
              end
              K_AHI:   hi_q   <= shreg_q[HI_BITS-1:0];
              K_ALO:   addr_q <= {hi_q, shreg_q};
              default: addr_q <= addr_q + 1'b1;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (kind_q == K_DEV && rw_q) begin
              state_q <= ST_TX;
              txbuf_q <= rd_data;
              addr_q  <= addr_q + 1'b1;
              oe_q    <= ~rd_data[7];
            end else begin
              state_q <= ST_RX;
              kind_q  <= next_kind(kind_q);
              oe_q    <= 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              state_q <= ST_RACK;
              cnt_q   <= '0;
              oe_q    <= 1'b0;
            end else begin
              cnt_q   <= cnt_q + 1'b1;
              txbuf_q <= {txbuf_q[6:0], 1'b0};
              oe_q    <= ~txbuf_q[6];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_q <= ST_TX;
              txbuf_q <= rd_data;
              addr_q  <= addr_q + 1'b1;
              oe_q    <= ~rd_data[7];
            end else begin
              state_q <= ST_IGNORE;
            end
          end
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_mem_checker.sv
module i2c_mem_checker
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              start_p,
  input logic              stop_p,
  input slv_state_e        state_q,
  input byte_kind_e        kind_q,
  input logic [ADDR_W-1:0] addr_q
);
  // R10: no data-line movement while the clock is high
  a_r10_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  // R2: a rejected identity keeps the line released
  a_r2_ignore_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !sda_oe);

  // R8: START ends any driving
  a_r8_release_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !sda_oe);

  // R8: STOP ends any driving
  a_r8_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !sda_oe);

  // R4 / R7: pointer only steps by one (mod 2^ADDR_W) or takes a loaded value
  a_r4_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_q != $past(addr_q)) |->
      ((addr_q == ADDR_W'($past(addr_q) + 1'b1)) ||
       ($past(state_q) == ST_RX && $past(kind_q) == K_ALO)));
endmodule

bind i2c_mem_slave i2c_mem_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_p(start_p), .stop_p(stop_p), .state_q(state_q),
  .kind_q(kind_q), .addr_q(addr_q)
);

// File: tb/test_i2c_mem_slave.sv
module test_i2c_mem_slave;
  localparam int Q     = 6;
  localparam int DEPTH = 512;
  localparam int AMASK = 16'h1FFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic quiet = 1'b0;
  bit   done = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  logic [7:0] mm [DEPTH];
  int         maddr = 0;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_slave i_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every-clock comparison against the model's expectation of silence
  always @(negedge clk) begin
    if (rst_n && quiet) chk(sda_oe == 1'b0, "R2 quiet", sda_oe, 0);
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b, output logic s);
    sda_m = b; wq(Q);
    scl_m = 1'b1; wq(Q);
    s = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic start_c();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic stop_c();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic wbyte(input logic [7:0] b, input bit exp_ack, input string req);
    logic s;
    for (int i = 7; i >= 0; i--) bit_out(b[i], s);
    bit_out(1'b1, s);
    chk(s == !exp_ack, req, s, !exp_ack);
  endtask

  // read 8 bits, compare against model; no 9th clock
  task automatic rbits(input string req);
    logic s;
    logic [7:0] v;
    logic [7:0] e;
    e = mm[maddr % DEPTH];
    for (int i = 7; i >= 0; i--) begin
      bit_out(1'b1, s);
      v[i] = s;
    end
    chk(v == e, req, v, e);
    maddr = (maddr + 1) & AMASK;
  endtask

  task automatic rbyte(input bit mack, input string req);
    logic s;
    rbits(req);
    bit_out(!mack, s);
  endtask

  task automatic mwrite(input int a, input logic [7:0] d[], input string req);
    start_c();
    wbyte(8'hA0, 1, req);
    wbyte(8'((a >> 8) & 8'h1F), 1, req);
    wbyte(8'(a & 8'hFF), 1, req);
    maddr = a;
    foreach (d[i]) begin
      wbyte(d[i], 1, req);
      mm[maddr % DEPTH] = d[i];
      maddr = (maddr + 1) & AMASK;
    end
  endtask

  task automatic set_ptr(input int a, input string req);
    start_c();
    wbyte(8'hA0, 1, req);
    wbyte(8'((a >> 8) & 8'h1F), 1, req);
    wbyte(8'(a & 8'hFF), 1, req);
    maddr = a;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mm[i] = 8'h00;
    wq(5);
    chk(sda_oe == 1'b0, "R1 oe in reset", sda_oe, 0);
    rst_n = 1'b1;
    wq(3);
    chk(sda_oe == 1'b0, "R1 oe after reset", sda_oe, 0);

    // R1: current read right after reset gives stored 00 at pointer 0
    start_c();
    wbyte(8'hA1, 1, "R1 read header");
    rbyte(0, "R1 reset content");
    stop_c();

    // R3 R4: write three bytes at 0010h
    mwrite(16'h0010, '{8'h11, 8'h22, 8'h33}, "R3 write");
    stop_c();

    // R6 R9: selective read with master ACKs, ended NACK+STOP (R8 way 1)
    set_ptr(16'h0010, "R6 pointer load");
    start_c();
    wbyte(8'hA1, 1, "R6 read header");
    rbyte(1, "R9 seq byte0");
    rbyte(1, "R9 seq byte1");
    rbyte(0, "R6 seq byte2");
    stop_c();
    wq(2);
    chk(sda_oe == 1'b0, "R8 nack+stop release", sda_oe, 0);

    // R5: current-pointer read continues at 0013h; ended NACK+START (R8 way 2)
    start_c();
    wbyte(8'hA1, 1, "R5 read header");
    rbyte(0, "R5 current read");
    start_c();
    chk(sda_oe == 1'b0, "R8 nack+start release", sda_oe, 0);
    wbyte(8'hA1, 1, "R5 read header 2");
    rbyte(0, "R5 continued read");
    stop_c();

    // R8 way 3: STOP in clock 9
    set_ptr(16'h0010, "R8 pointer load");
    start_c();
    wbyte(8'hA1, 1, "R8 header");
    rbits("R8 read before stop");
    stop_c();
    wq(2);
    chk(sda_oe == 1'b0, "R8 stop in clock 9", sda_oe, 0);

    // R8 way 4: START in clock 9, then the pointer continues (0012h)
    start_c();
    wbyte(8'hA1, 1, "R8 header 2");
    rbits("R8 read before start");
    start_c();
    chk(sda_oe == 1'b0, "R8 start in clock 9", sda_oe, 0);
    wbyte(8'hA1, 1, "R8 header 3");
    rbyte(0, "R8 pointer after start");
    stop_c();

    // R7: rollover on write and on read
    mwrite(16'h1FFF, '{8'hAA, 8'hBB}, "R7 write wrap");
    stop_c();
    set_ptr(16'h1FFF, "R7 pointer load");
    start_c();
    wbyte(8'hA1, 1, "R7 header");
    rbyte(1, "R7 read 1FFF");
    rbyte(0, "R7 read 0000");
    stop_c();

    // R11: pointer 0205h aliases byte 0005h in a 512-byte store
    mwrite(16'h0205, '{8'h5C}, "R11 write");
    stop_c();
    set_ptr(16'h0005, "R11 pointer load");
    start_c();
    wbyte(8'hA1, 1, "R11 header");
    rbyte(0, "R11 alias read");
    stop_c();

    // R2: wrong identity, nothing acknowledged, nothing stored
    start_c();
    quiet = 1'b1;
    wbyte(8'hB0, 0, "R2 mismatch header");
    wbyte(8'h00, 0, "R2 mismatch byte");
    wbyte(8'h10, 0, "R2 mismatch byte");
    wbyte(8'h99, 0, "R2 mismatch data");
    quiet = 1'b0;
    stop_c();
    set_ptr(16'h0010, "R2 pointer load");
    start_c();
    wbyte(8'hA1, 1, "R2 header");
    rbyte(0, "R2 content unchanged");
    stop_c();

    wq(4);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule